// File: doc/BRIEF.md
# Flash Program/Erase Error-Protection Controller

This block sits beside an embedded flash array and guards its program and erase phases. It holds a small control register with four fields: program enable, erase enable, program-verify enable and erase-verify enable. It also holds a block-select register with one bit per erase block. From these registers it drives the array-level enables.

While a program or erase operation is live, the block watches strobes from the CPU side for events that must not happen during a high-voltage phase. These are a read of the array, entry into a non-reset exception, a sleep or standby entry, and loss of bus ownership. Any of them latches a sticky error flag, raises a one-cycle abort pulse and removes the program and erase enables at once. The register contents stay as they were, so software can inspect them. Verify modes remain reachable, but program and erase can never be entered again until a reset or hardware standby clears the flag. Entering software standby wipes the registers but keeps the error flag.

Top module: `fpg_guard`

## Requirements
- R1: While program or erase is active (prog_en_o or erase_en_o high), an array read strobe sets err_o at the next clock edge.
- R2: While program or erase is active, an exception-entry strobe sets err_o unless the exception-is-reset qualifier is high, in which case err_o stays 0.
- R3: While program or erase is active, a sleep strobe or a software-standby entry sets err_o.
- R4: While program or erase is active, a bus-loss strobe sets err_o.
- R5: Event strobes that arrive while neither prog_en_o nor erase_en_o is high leave err_o at 0.
- R6: In the cycle err_o first reads 1, abort_o is high for exactly that one cycle and prog_en_o and erase_en_o are low. The control value on ctrl_q_o and the block selection on blk_sel_o keep their pre-error contents.
- R7: While err_o is 1, a control write leaves the program (bit 0) and erase (bit 1) fields unchanged. The program-verify (bit 2) and erase-verify (bit 3) fields still take the written value.
- R8: A control write with bit 0 and bit 1 both set stores 0 in both fields, so no operation starts.
- R9: A control write that sets bit 0 or bit 1 while bit 2 or bit 3 of the same write is 1 stores 0 in bits 0 and 1. The verify bits are stored as written.
- R10: An active-low reset, or hardware standby held high at a clock edge, clears err_o, ctrl_q_o and blk_sel_o.
- R11: A software-standby strobe clears ctrl_q_o and blk_sel_o at the next edge and leaves err_o unchanged.
- R12: A legal control write appears on ctrl_q_o one cycle later. With err_o at 0, prog_en_o and erase_en_o follow bits 0 and 1 of ctrl_q_o.

Writes on ctrl_wdata_i and blk_wdata_i take effect at the clock edge where their write strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby_i | input | 1 | Hardware standby, clears everything at the edge |
| sw_stby_i | input | 1 | Software standby entry strobe |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data: bit0 program, bit1 erase, bit2 program-verify, bit3 erase-verify |
| blk_we_i | input | 1 | Block-select register write strobe |
| blk_wdata_i | input | NBLK | Block-select write data |
| ev_rd_i | input | 1 | Array read (data, vector or fetch) strobe |
| ev_exc_i | input | 1 | Exception-entry strobe |
| ev_exc_rst_i | input | 1 | Qualifies ev_exc_i as a reset exception |
| ev_sleep_i | input | 1 | Sleep instruction strobe |
| ev_busloss_i | input | 1 | CPU gave the bus to another master |
| ctrl_q_o | output | 4 | Control register contents |
| blk_sel_o | output | NBLK | Block-select register contents |
| prog_en_o | output | 1 | Array program enable |
| erase_en_o | output | 1 | Array erase enable |
| pverify_en_o | output | 1 | Program-verify enable |
| everify_en_o | output | 1 | Erase-verify enable |
| err_o | output | 1 | Sticky error flag |
| abort_o | output | 1 | One-cycle abort pulse |

## Verification
The assertions assume that the event strobes and write strobes are synchronous to clk and stable around the rising edge. They also assume that hardware standby is a level sampled at the edge. Software standby entry is treated as a single-cycle strobe; a held level is not assumed. The bench changes every input only on the falling edge and raises at most one event strobe per cycle, so each error has a single known cause. Hardware standby is used between scenarios to return to a known state, so no check depends on what the previous scenario left behind.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    // Field order matches the write-data bit positions (bit0 = prog).
    typedef struct packed {
        logic everify;
        logic pverify;
        logic erase;
        logic prog;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // A start request is legal only if it asks for one operation and no verify.
    function automatic logic start_conflict(input ctrl_t w);
        return (w.prog && w.erase) ||
               ((w.prog || w.erase) && (w.pverify || w.everify));
    endfunction

endpackage

// File: rtl/fpg_event_mon.sv
module fpg_event_mon #(
    parameter int NEV = 5
) (
    input  logic           active_i,
    input  logic           ev_rd_i,
    input  logic           ev_exc_i,
    input  logic           ev_exc_rst_i,
    input  logic           ev_sleep_i,
    input  logic           sw_stby_i,
    input  logic           ev_busloss_i,
    output logic           illegal_o
);
    logic [NEV-1:0] cause;

    always_comb begin
        cause    = '0;
        cause[0] = ev_rd_i;
        cause[1] = ev_exc_i && !ev_exc_rst_i;
        cause[2] = ev_sleep_i;
        cause[3] = sw_stby_i;
        cause[4] = ev_busloss_i;
        illegal_o = active_i && (|cause);
    end

endmodule

// File: rtl/fpg_reg_file.sv
module fpg_reg_file
    import fpg_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_stby_i,
    input  logic            sw_stby_i,
    input  logic            illegal_i,
    input  logic            ctrl_we_i,
    input  ctrl_t           ctrl_wdata_i,
    input  logic            blk_we_i,
    input  logic [NBLK-1:0] blk_wdata_i,
    output ctrl_t           ctrl_o,
    output logic [NBLK-1:0] blk_o,
    output logic            err_o,
    output logic            abort_o
);
    typedef struct packed {
        ctrl_t           ctrl;
        logic [NBLK-1:0] blk;
        logic            err;
        logic            abort;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;

        if (illegal_i) begin
            st_d.err   = 1'b1;
            st_d.abort = 1'b1;
        end

        if (ctrl_we_i) begin
            st_d.ctrl.pverify = ctrl_wdata_i.pverify;
            st_d.ctrl.everify = ctrl_wdata_i.everify;
            if (!st_q.err) begin
                if (start_conflict(ctrl_wdata_i)) begin
                    st_d.ctrl.prog  = 1'b0;
                    st_d.ctrl.erase = 1'b0;
                end else begin
                    st_d.ctrl.prog  = ctrl_wdata_i.prog;
                    st_d.ctrl.erase = ctrl_wdata_i.erase;
                end
            end
        end

        if (blk_we_i) begin
            st_d.blk = blk_wdata_i;
        end

        if (sw_stby_i) begin
            st_d.ctrl = '0;
            st_d.blk  = '0;
        end

        if (hw_stby_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o  = st_q.ctrl;
    assign blk_o   = st_q.blk;
    assign err_o   = st_q.err;
    assign abort_o = st_q.abort;

    // R8: program and erase are never stored together
    a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ctrl.prog && st_q.ctrl.erase));

    // R7: under error, a cleared program/erase bit cannot become set
    a_r7_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !st_q.ctrl.prog && !st_q.ctrl.erase)
        |=> (!st_q.ctrl.prog && !st_q.ctrl.erase));

    // R10: the flag is sticky until hardware standby
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !hw_stby_i) |=> st_q.err);

    // R11: software standby empties the registers
    a_r11_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stby_i |=> (st_q.ctrl == '0 && st_q.blk == '0));

endmodule

// File: rtl/fpg_guard.sv
module fpg_guard
    import fpg_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby_i,
    input  logic              sw_stby_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              blk_we_i,
    input  logic [NBLK-1:0]   blk_wdata_i,
    input  logic              ev_rd_i,
    input  logic              ev_exc_i,
    input  logic              ev_exc_rst_i,
    input  logic              ev_sleep_i,
    input  logic              ev_busloss_i,
    output logic [CTRL_W-1:0] ctrl_q_o,
    output logic [NBLK-1:0]   blk_sel_o,
    output logic              prog_en_o,
    output logic              erase_en_o,
    output logic              pverify_en_o,
    output logic              everify_en_o,
    output logic              err_o,
    output logic              abort_o
);
    ctrl_t ctrl;
    logic  err;
    logic  illegal;
    logic  active;

    assign prog_en_o    = ctrl.prog  && !err;
    assign erase_en_o   = ctrl.erase && !err;
    assign pverify_en_o = ctrl.pverify;
    assign everify_en_o = ctrl.everify;
    assign active       = prog_en_o || erase_en_o;
    assign ctrl_q_o     = ctrl;
    assign err_o        = err;

    fpg_event_mon #(.NEV(5)) u_mon (
        .active_i     (active),
        .ev_rd_i      (ev_rd_i),
        .ev_exc_i     (ev_exc_i),
        .ev_exc_rst_i (ev_exc_rst_i),
        .ev_sleep_i   (ev_sleep_i),
        .sw_stby_i    (sw_stby_i),
        .ev_busloss_i (ev_busloss_i),
        .illegal_o    (illegal)
    );

    fpg_reg_file #(.NBLK(NBLK)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_stby_i    (hw_stby_i),
        .sw_stby_i    (sw_stby_i),
        .illegal_i    (illegal),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_t'(ctrl_wdata_i)),
        .blk_we_i     (blk_we_i),
        .blk_wdata_i  (blk_wdata_i),
        .ctrl_o       (ctrl),
        .blk_o        (blk_sel_o),
        .err_o        (err),
        .abort_o      (abort_o)
    );

    // R6: abort lasts a single cycle
    a_r6_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R6: the flag rises together with the abort pulse
    a_r6_rise_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !hw_stby_i) |=> (err_o == abort_o));

    // R6: an abort only follows a live operation
    a_r6_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> !abort_o);

    // R5: strobes outside program/erase never raise the flag
    a_r5_idle_events: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !err_o) |=> !err_o);

endmodule

// File: tb/fpg_guard_tb_top.sv
module fpg_guard_tb_top;

    localparam int NBLK = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hw_stby_i = 1'b0, sw_stby_i = 1'b0;
    logic            ctrl_we_i = 1'b0, blk_we_i = 1'b0;
    logic [3:0]      ctrl_wdata_i = '0;
    logic [NBLK-1:0] blk_wdata_i = '0;
    logic            ev_rd_i = 1'b0, ev_exc_i = 1'b0, ev_exc_rst_i = 1'b0;
    logic            ev_sleep_i = 1'b0, ev_busloss_i = 1'b0;
    logic [3:0]      ctrl_q_o;
    logic [NBLK-1:0] blk_sel_o;
    logic            prog_en_o, erase_en_o, pverify_en_o, everify_en_o;
    logic            err_o, abort_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    fpg_guard #(.NBLK(NBLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_stby_i(hw_stby_i), .sw_stby_i(sw_stby_i),
        .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
        .blk_we_i(blk_we_i), .blk_wdata_i(blk_wdata_i),
        .ev_rd_i(ev_rd_i), .ev_exc_i(ev_exc_i), .ev_exc_rst_i(ev_exc_rst_i),
        .ev_sleep_i(ev_sleep_i), .ev_busloss_i(ev_busloss_i),
        .ctrl_q_o(ctrl_q_o), .blk_sel_o(blk_sel_o),
        .prog_en_o(prog_en_o), .erase_en_o(erase_en_o),
        .pverify_en_o(pverify_en_o), .everify_en_o(everify_en_o),
        .err_o(err_o), .abort_o(abort_o)
    );

    // event codes: 0 none, 1 read, 2 exception, 3 reset exception,
    // 4 sleep, 5 bus loss, 6 software standby, 7 hardware standby
    typedef struct packed {
        logic       we;
        logic [3:0] wd;
        logic [2:0] ev;
        logic [3:0] req;
        logic [3:0] x_ctrl;
        logic [1:0] x_en;   // {erase_en, prog_en}
        logic       x_err;
        logic       x_abort;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 4'h1, 3'd0, 4'd12, 4'h1, 2'b01, 1'b0, 1'b0}, // R12 start program
        '{1'b0, 4'h0, 3'd1, 4'd1,  4'h1, 2'b00, 1'b1, 1'b1}, // R1 read aborts, R6 retained
        '{1'b0, 4'h0, 3'd0, 4'd6,  4'h1, 2'b00, 1'b1, 1'b0}, // R6 single pulse
        '{1'b1, 4'h2, 3'd0, 4'd7,  4'h1, 2'b00, 1'b1, 1'b0}, // R7 erase write ignored
        '{1'b1, 4'h4, 3'd0, 4'd7,  4'h5, 2'b00, 1'b1, 1'b0}, // R7 verify still writable
        '{1'b0, 4'h0, 3'd7, 4'd10, 4'h0, 2'b00, 1'b0, 1'b0}, // R10 hw standby clears
        '{1'b0, 4'h0, 3'd1, 4'd5,  4'h0, 2'b00, 1'b0, 1'b0}, // R5 idle read
        '{1'b0, 4'h0, 3'd5, 4'd5,  4'h0, 2'b00, 1'b0, 1'b0}, // R5 idle bus loss
        '{1'b1, 4'h2, 3'd0, 4'd12, 4'h2, 2'b10, 1'b0, 1'b0}, // R12 start erase
        '{1'b0, 4'h0, 3'd3, 4'd2,  4'h2, 2'b10, 1'b0, 1'b0}, // R2 reset exception tolerated
        '{1'b0, 4'h0, 3'd2, 4'd2,  4'h2, 2'b00, 1'b1, 1'b1}, // R2 exception aborts
        '{1'b0, 4'h0, 3'd7, 4'd10, 4'h0, 2'b00, 1'b0, 1'b0}, // R10
        '{1'b1, 4'h3, 3'd0, 4'd8,  4'h0, 2'b00, 1'b0, 1'b0}, // R8 both refused
        '{1'b1, 4'h5, 3'd0, 4'd9,  4'h4, 2'b00, 1'b0, 1'b0}, // R9 prog with verify refused
        '{1'b1, 4'h0, 3'd0, 4'd12, 4'h0, 2'b00, 1'b0, 1'b0}, // R12 clear
        '{1'b1, 4'h1, 3'd0, 4'd12, 4'h1, 2'b01, 1'b0, 1'b0}, // R12 program again
        '{1'b0, 4'h0, 3'd4, 4'd3,  4'h1, 2'b00, 1'b1, 1'b1}, // R3 sleep aborts
        '{1'b0, 4'h0, 3'd7, 4'd10, 4'h0, 2'b00, 1'b0, 1'b0}, // R10
        '{1'b1, 4'h2, 3'd0, 4'd12, 4'h2, 2'b10, 1'b0, 1'b0}, // R12 erase
        '{1'b0, 4'h0, 3'd5, 4'd4,  4'h2, 2'b00, 1'b1, 1'b1}, // R4 bus loss aborts
        '{1'b0, 4'h0, 3'd6, 4'd11, 4'h0, 2'b00, 1'b1, 1'b0}, // R11 sw standby keeps flag
        '{1'b0, 4'h0, 3'd7, 4'd10, 4'h0, 2'b00, 1'b0, 1'b0}, // R10
        '{1'b1, 4'h1, 3'd0, 4'd12, 4'h1, 2'b01, 1'b0, 1'b0}, // R12
        '{1'b0, 4'h0, 3'd6, 4'd3,  4'h0, 2'b00, 1'b1, 1'b1}, // R3 standby entry aborts
        '{1'b1, 4'h8, 3'd0, 4'd7,  4'h8, 2'b00, 1'b1, 1'b0}  // R7 verify under error
    };

    task automatic drive(input logic we, input logic [3:0] wd, input logic [2:0] ev);
        ctrl_we_i    = we;
        ctrl_wdata_i = wd;
        ev_rd_i      = (ev == 3'd1);
        ev_exc_i     = (ev == 3'd2) || (ev == 3'd3);
        ev_exc_rst_i = (ev == 3'd3);
        ev_sleep_i   = (ev == 3'd4);
        ev_busloss_i = (ev == 3'd5);
        sw_stby_i    = (ev == 3'd6);
        hw_stby_i    = (ev == 3'd7);
    endtask

    task automatic idle();
        drive(1'b0, 4'h0, 3'd0);
        blk_we_i = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] obs();
        return {24'h0, ctrl_q_o, erase_en_o, prog_en_o, err_o, abort_o};
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset ctrl/err", obs(), 32'h0);
        check("R10 reset blk", {24'h0, blk_sel_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].we, TBL[i].wd, TBL[i].ev);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", TBL[i].req, i), obs(),
                  {24'h0, TBL[i].x_ctrl, TBL[i].x_en, TBL[i].x_err, TBL[i].x_abort});
        end

        // Directed: block select retained on error, cleared by sw standby (R6, R11)
        idle(); hw_stby_i = 1'b1; @(negedge clk); idle();
        blk_we_i = 1'b1; blk_wdata_i = 8'hA5; @(negedge clk); idle();
        drive(1'b1, 4'h1, 3'd0); @(negedge clk);
        drive(1'b0, 4'h0, 3'd1); @(negedge clk);
        check("R6 blk kept on abort", {24'h0, blk_sel_o}, 32'hA5);
        check("R6 abort with enables low", obs(), {24'h0, 4'h1, 2'b00, 1'b1, 1'b1});
        drive(1'b0, 4'h0, 3'd6); @(negedge clk); idle();
        check("R11 blk cleared", {24'h0, blk_sel_o}, 32'h0);
        check("R11 flag kept", {31'h0, err_o}, 32'h1);

        // Directed: verify enables visible under error (R7)
        drive(1'b1, 4'hC, 3'd0); @(negedge clk); idle();
        check("R7 verify outputs", {30'h0, everify_en_o, pverify_en_o}, 32'h3);

        // Directed: async reset clears the flag (R10)
        #2 rst_n = 1'b0; #2;
        check("R10 async reset", obs(), 32'h0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R10 stays clear", obs(), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule